// File: doc/BRIEF.md
# NCO Quadrature Upconversion Modulator

This block places a complex baseband signal onto a digital carrier. Each valid clock it takes one signed 14-bit in-phase sample and one signed 14-bit quadrature sample. It multiplies them by the cosine and sine of a numerically controlled oscillator and returns one real 14-bit sample, two clocks later. The oscillator is a 32-bit phase accumulator. Its step, the tuning word M, gives a carrier of M·fs/2^32.

Configuration arrives over a byte-wide write port.

- The four tuning-word bytes are staged in a shadow register. They take effect together only when the most significant byte is written.
- A 16-bit phase offset is added to the accumulator before the sine/cosine lookup.
- A control byte has three switches:
  - one reverses the sign of the sine product, which swaps the upper and lower sideband;
  - one selects a coarse low-power mode that uses only five bits of frequency and phase;
  - one scales the modulator output by 181/256 (about −3 dB), so that full-scale I and Q together do not clip.

Top module: `nco_qmod`

## Requirements
- R1: Reset (synchronous, active high) clears `out_valid`, the accumulator and the phase offset. It clears all control switches. It loads the tuning word 0x26666666.
- R2: Config addresses 0, 1 and 2 write tuning bits [7:0], [15:8] and [23:16] into a shadow register and leave the active tuning word unchanged. Address 3 loads the active word with {wdata, shadow[23:0]} in one step.
- R3: Address 4 writes phase-offset bits [7:0] and address 5 writes bits [15:8]. Each takes effect for samples accepted after the write edge.
- R4: The accumulator advances by the active step only on clocks with `in_valid` high. Otherwise it holds.
- R5: In normal mode the lookup phase is the 10-bit value ((acc[31:16] + offset) mod 2^16) >> 6. The output is round((I·2047·cos θ − Q·2047·sin θ)/2048), with θ = 2π(p+0.5)/1024. It appears with `out_valid` exactly two clocks after the sample is accepted.
- R6: Control bit 0 (address 6) set reverses the sign of the sine product: output ≈ I·cos θ + Q·sin θ.
- R7: Control bit 1 set selects low-power mode:
  - the step becomes {M[31:27], 27'b0};
  - the lookup phase becomes ((acc[31:27] + offset[15:11]) mod 32) << 5;
  - accumulator bits [26:0] no longer change.
- R8: Control bit 2 set multiplies the modulator result by 181/256 before rounding.
- R9: The result saturates to the 14-bit two's-complement range [−8192, 8191]. Rounding error against the ideal stays within 4 LSB.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 3 | Configuration register address |
| cfg_wdata | input | 8 | Configuration write byte |
| in_valid | input | 1 | I/Q sample pair present this clock |
| i_in | input | 14 | In-phase sample, signed |
| q_in | input | 14 | Quadrature sample, signed |
| out_valid | output | 1 | Output sample present |
| out_sample | output | 14 | Modulated real sample, signed |

## Verification
An I-only ramp with Q at zero isolates the cosine path. Equal non-zero I and Q then expose the sign of the sine path, so a sideband inversion cannot pass unnoticed. Full-scale I and Q of both signs separate saturation from wrap-around, and with the −3 dB switch on, the same stimulus shows the 181/256 scaling. Gapped `in_valid`, partial tuning writes, phase-offset writes and the coarse mode each move the carrier phase in a way a per-clock behavioural model tracks cycle for cycle.

// File: rtl/nco_qmod_pkg.sv
package nco_qmod_pkg;
    localparam int CFG_AW = 3;
    localparam logic [CFG_AW-1:0] A_TUNE0 = 3'd0;
    localparam logic [CFG_AW-1:0] A_TUNE1 = 3'd1;
    localparam logic [CFG_AW-1:0] A_TUNE2 = 3'd2;
    localparam logic [CFG_AW-1:0] A_TUNE3 = 3'd3;
    localparam logic [CFG_AW-1:0] A_PHS0  = 3'd4;
    localparam logic [CFG_AW-1:0] A_PHS1  = 3'd5;
    localparam logic [CFG_AW-1:0] A_CTRL  = 3'd6;
    localparam int CB_INV = 0;
    localparam int CB_LP  = 1;
    localparam int CB_M3  = 2;
    localparam logic [31:0] TUNE_RESET = 32'h2666_6666;

    typedef struct packed {
        logic inv;
        logic lp;
        logic m3;
    } ctrl_t;
endpackage

// File: rtl/nco_qmod_regs.sv
module nco_qmod_regs
    import nco_qmod_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_we,
    input  logic [CFG_AW-1:0] cfg_addr,
    input  logic [7:0]        cfg_wdata,
    output logic [31:0]       tune,
    output logic [15:0]       phase_off,
    output ctrl_t             ctrl
);
    typedef struct packed {
        logic [23:0] shadow;
        logic [31:0] tune;
        logic [15:0] phoff;
        ctrl_t       ctrl;
    } reg_st_t;

    reg_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (cfg_we) begin
            case (cfg_addr)
                A_TUNE0: st_d.shadow[7:0]   = cfg_wdata;
                A_TUNE1: st_d.shadow[15:8]  = cfg_wdata;
                A_TUNE2: st_d.shadow[23:16] = cfg_wdata;
                A_TUNE3: st_d.tune          = {cfg_wdata, st_q.shadow};
                A_PHS0:  st_d.phoff[7:0]    = cfg_wdata;
                A_PHS1:  st_d.phoff[15:8]   = cfg_wdata;
                A_CTRL: begin
                    st_d.ctrl.inv = cfg_wdata[CB_INV];
                    st_d.ctrl.lp  = cfg_wdata[CB_LP];
                    st_d.ctrl.m3  = cfg_wdata[CB_M3];
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q.shadow <= TUNE_RESET[23:0];
            st_q.tune   <= TUNE_RESET;
            st_q.phoff  <= '0;
            st_q.ctrl   <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign tune      = st_q.tune;
    assign phase_off = st_q.phoff;
    assign ctrl      = st_q.ctrl;
endmodule

// File: rtl/nco_qmod_phase.sv
module nco_qmod_phase #(
    parameter int ACC_W   = 32,
    parameter int PH_W    = 16,
    parameter int IDX_W   = 10,
    parameter int LP_BITS = 5
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             adv,
    input  logic             lp,
    input  logic [ACC_W-1:0] tune,
    input  logic [PH_W-1:0]  phase_off,
    output logic [IDX_W-1:0] idx,
    output logic [ACC_W-1:0] acc
);
    localparam int LOW_W   = ACC_W - LP_BITS;
    localparam int IDX_PAD = IDX_W - LP_BITS;

    typedef struct packed {
        logic [ACC_W-1:0] acc;
    } ph_st_t;

    ph_st_t st_d, st_q;
    logic [ACC_W-1:0]   step;
    logic [PH_W-1:0]    fine_sum;
    logic [LP_BITS-1:0] coarse_sum;

    always_comb begin
        step       = lp ? {tune[ACC_W-1 -: LP_BITS], {LOW_W{1'b0}}} : tune;
        st_d       = st_q;
        if (adv) st_d.acc = st_q.acc + step;
        fine_sum   = st_q.acc[ACC_W-1 -: PH_W] + phase_off;
        coarse_sum = st_q.acc[ACC_W-1 -: LP_BITS] + phase_off[PH_W-1 -: LP_BITS];
        idx        = lp ? {coarse_sum, {IDX_PAD{1'b0}}} : fine_sum[PH_W-1 -: IDX_W];
    end

    always_ff @(posedge clk) begin
        if (rst) st_q.acc <= '0;
        else     st_q     <= st_d;
    end

    assign acc = st_q.acc;
endmodule

// File: rtl/nco_qmod_trig.sv
module nco_qmod_trig #(
    parameter int IDX_W = 10,
    parameter int AMP_W = 12
) (
    input  logic [IDX_W-1:0]        idx,
    output logic signed [AMP_W-1:0] sin_v,
    output logic signed [AMP_W-1:0] cos_v
);
    localparam int     QA_W   = IDX_W - 2;
    localparam int     N      = 1 << QA_W;
    localparam longint FULL   = (64'sd1 << (AMP_W - 1)) - 1;
    localparam longint ONE    = 64'sd1 << 30;
    localparam longint PI_Q30 = 64'sd3373259426;

    // sin(pi/2 * (i + 0.5) / N) scaled to FULL, Taylor series in Q30
    function automatic longint sin_q(input int i);
        longint x, term, sum;
        x    = (PI_Q30 * longint'(2 * i + 1)) / longint'(4 * N);
        term = x;
        sum  = x;
        for (int k = 1; k <= 6; k++) begin
            term = -((term * x) / ONE);
            term = (term * x) / ONE;
            term = term / longint'((2 * k) * (2 * k + 1));
            sum  = sum + term;
        end
        return (sum * FULL + ONE / 2) / ONE;
    endfunction

    logic [AMP_W-2:0] rom [N];

    for (genvar g = 0; g < N; g++) begin : g_rom
        localparam longint VAL = sin_q(g);
        assign rom[g] = (AMP_W-1)'(VAL);
    end

    logic [IDX_W-1:0]        cidx;
    logic [QA_W-1:0]         sa, ca;
    logic signed [AMP_W-1:0] smag, cmag;

    always_comb begin
        cidx  = idx + IDX_W'(N);
        sa    = idx[IDX_W-2]  ? ~idx[QA_W-1:0]  : idx[QA_W-1:0];
        ca    = cidx[IDX_W-2] ? ~cidx[QA_W-1:0] : cidx[QA_W-1:0];
        smag  = {1'b0, rom[sa]};
        cmag  = {1'b0, rom[ca]};
        sin_v = idx[IDX_W-1]  ? -smag : smag;
        cos_v = cidx[IDX_W-1] ? -cmag : cmag;
    end
endmodule

// File: rtl/nco_qmod_mixer.sv
module nco_qmod_mixer #(
    parameter int DATA_W = 14,
    parameter int AMP_W  = 12
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     in_valid,
    input  logic signed [DATA_W-1:0] i_in,
    input  logic signed [DATA_W-1:0] q_in,
    input  logic signed [AMP_W-1:0]  sin_v,
    input  logic signed [AMP_W-1:0]  cos_v,
    input  logic                     inv,
    input  logic                     m3,
    output logic                     out_valid,
    output logic signed [DATA_W-1:0] out_sample
);
    localparam int PROD_W = DATA_W + AMP_W;
    localparam int SUM_W  = PROD_W + 1;
    localparam int SC_W   = SUM_W + 10;
    localparam int SH     = (AMP_W - 1) + 8;
    localparam logic signed [SC_W-1:0] HALF = {{(SC_W-SH){1'b0}}, 1'b1, {(SH-1){1'b0}}};
    localparam logic signed [SC_W-1:0] MAXV = SC_W'((1 << (DATA_W - 1)) - 1);
    localparam logic signed [SC_W-1:0] MINV = SC_W'(-(1 << (DATA_W - 1)));

    typedef struct packed {
        logic                     v1;
        logic signed [DATA_W-1:0] i;
        logic signed [DATA_W-1:0] q;
        logic signed [AMP_W-1:0]  s;
        logic signed [AMP_W-1:0]  c;
        logic                     inv;
        logic                     m3;
        logic                     v2;
        logic signed [DATA_W-1:0] y;
    } mx_st_t;

    mx_st_t st_d, st_q;
    logic signed [PROD_W-1:0] p_i, p_q;
    logic signed [SUM_W-1:0]  sum;
    logic signed [9:0]        gain;
    logic signed [SC_W-1:0]   scaled, shifted;

    always_comb begin
        st_d     = st_q;
        st_d.v1  = in_valid;
        st_d.i   = i_in;
        st_d.q   = q_in;
        st_d.s   = sin_v;
        st_d.c   = cos_v;
        st_d.inv = inv;
        st_d.m3  = m3;

        p_i     = st_q.i * st_q.c;
        p_q     = st_q.q * st_q.s;
        sum     = st_q.inv ? ({p_i[PROD_W-1], p_i} + {p_q[PROD_W-1], p_q})
                           : ({p_i[PROD_W-1], p_i} - {p_q[PROD_W-1], p_q});
        gain    = st_q.m3 ? 10'sd181 : 10'sd256;
        scaled  = sum * gain;
        shifted = (scaled + HALF) >>> SH;
        st_d.v2 = st_q.v1;
        if (shifted > MAXV)      st_d.y = MAXV[DATA_W-1:0];
        else if (shifted < MINV) st_d.y = MINV[DATA_W-1:0];
        else                     st_d.y = shifted[DATA_W-1:0];
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    assign out_valid  = st_q.v2;
    assign out_sample = st_q.y;
endmodule

// File: rtl/nco_qmod.sv
module nco_qmod
    import nco_qmod_pkg::*;
#(
    parameter int DATA_W  = 14,
    parameter int AMP_W   = 12,
    parameter int IDX_W   = 10,
    parameter int LP_BITS = 5
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     cfg_we,
    input  logic [2:0]               cfg_addr,
    input  logic [7:0]               cfg_wdata,
    input  logic                     in_valid,
    input  logic signed [DATA_W-1:0] i_in,
    input  logic signed [DATA_W-1:0] q_in,
    output logic                     out_valid,
    output logic signed [DATA_W-1:0] out_sample
);
    localparam int ACC_W = 32;
    localparam int PH_W  = 16;

    logic [ACC_W-1:0]        tune;
    logic [PH_W-1:0]         phase_off;
    ctrl_t                   ctrl;
    logic [IDX_W-1:0]        idx;
    logic [ACC_W-1:0]        acc;
    logic signed [AMP_W-1:0] sin_v, cos_v;

    nco_qmod_regs u_regs (
        .clk       (clk),
        .rst       (rst),
        .cfg_we    (cfg_we),
        .cfg_addr  (cfg_addr),
        .cfg_wdata (cfg_wdata),
        .tune      (tune),
        .phase_off (phase_off),
        .ctrl      (ctrl)
    );

    nco_qmod_phase #(
        .ACC_W   (ACC_W),
        .PH_W    (PH_W),
        .IDX_W   (IDX_W),
        .LP_BITS (LP_BITS)
    ) u_phase (
        .clk       (clk),
        .rst       (rst),
        .adv       (in_valid),
        .lp        (ctrl.lp),
        .tune      (tune),
        .phase_off (phase_off),
        .idx       (idx),
        .acc       (acc)
    );

    nco_qmod_trig #(
        .IDX_W (IDX_W),
        .AMP_W (AMP_W)
    ) u_trig (
        .idx   (idx),
        .sin_v (sin_v),
        .cos_v (cos_v)
    );

    nco_qmod_mixer #(
        .DATA_W (DATA_W),
        .AMP_W  (AMP_W)
    ) u_mixer (
        .clk        (clk),
        .rst        (rst),
        .in_valid   (in_valid),
        .i_in       (i_in),
        .q_in       (q_in),
        .sin_v      (sin_v),
        .cos_v      (cos_v),
        .inv        (ctrl.inv),
        .m3         (ctrl.m3),
        .out_valid  (out_valid),
        .out_sample (out_sample)
    );
endmodule

// File: rtl/nco_qmod_chk.sv
module nco_qmod_chk (
    input logic        clk,
    input logic        rst,
    input logic        cfg_we,
    input logic [2:0]  cfg_addr,
    input logic [7:0]  cfg_wdata,
    input logic        in_valid,
    input logic        lp,
    input logic [31:0] tune,
    input logic [31:0] acc,
    input logic        out_valid
);
    // R2: lower tuning bytes only reach the shadow
    a_r2_shadow_only: assert property (@(posedge clk) disable iff (rst)
        (cfg_we && cfg_addr < 3'd3) |=> $stable(tune));

    // R2: top byte write commits the whole word
    a_r2_commit: assert property (@(posedge clk) disable iff (rst)
        (cfg_we && cfg_addr == 3'd3) |=> (tune[31:24] == $past(cfg_wdata)));

    // R4: no sample, no phase movement
    a_r4_hold: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> $stable(acc));

    // R5: fixed two-clock latency of the valid flag
    a_r5_latency: assert property (@(posedge clk) disable iff (rst)
        out_valid == $past(in_valid, 2));

    // R7: coarse mode leaves the fine accumulator bits alone
    a_r7_coarse_step: assert property (@(posedge clk) disable iff (rst)
        (in_valid && lp) |=> (acc[26:0] == $past(acc[26:0])));
endmodule

bind nco_qmod nco_qmod_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .cfg_we    (cfg_we),
    .cfg_addr  (cfg_addr),
    .cfg_wdata (cfg_wdata),
    .in_valid  (in_valid),
    .lp        (ctrl.lp),
    .tune      (tune),
    .acc       (acc),
    .out_valid (out_valid)
);

// File: tb/nco_qmod_tb.sv
module nco_qmod_tb;
    localparam int CLK_P = 10;
    localparam int TOL   = 4;
    localparam real PI   = 3.14159265358979;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              cfg_we = 1'b0;
    logic [2:0]        cfg_addr = '0;
    logic [7:0]        cfg_wdata = '0;
    logic              in_valid = 1'b0;
    logic signed [13:0] i_in = '0;
    logic signed [13:0] q_in = '0;
    logic              out_valid;
    logic signed [13:0] out_sample;

    always #(CLK_P/2) clk = ~clk;

    nco_qmod u_dut (
        .clk        (clk),
        .rst        (rst),
        .cfg_we     (cfg_we),
        .cfg_addr   (cfg_addr),
        .cfg_wdata  (cfg_wdata),
        .in_valid   (in_valid),
        .i_in       (i_in),
        .q_in       (q_in),
        .out_valid  (out_valid),
        .out_sample (out_sample)
    );

    int n_checks = 0;
    int n_fail   = 0;
    string cur   = "R1";

    // behavioural model state
    bit [31:0] m_tune  = 32'h2666_6666;
    bit [23:0] m_sh    = 24'h66_6666;
    bit [15:0] m_phoff = '0;
    bit [31:0] m_acc   = '0;
    bit m_inv = 0, m_lp = 0, m_m3 = 0;

    bit    pv [2];
    int    pe [2];
    string pt [2];

    function automatic int model_out(int iv, int qv);
        int p10;
        real th, y;
        int r;
        if (m_lp) p10 = int'(((m_acc >> 27) + 32'(m_phoff >> 11)) & 32'h1F) * 32;
        else      p10 = int'(((m_acc >> 16) + 32'(m_phoff)) & 32'hFFFF) / 64;
        th = 2.0 * PI * (real'(p10) + 0.5) / 1024.0;
        y  = (real'(iv) * 2047.0 * $cos(th)
              - (m_inv ? -1.0 : 1.0) * real'(qv) * 2047.0 * $sin(th)) / 2048.0;
        if (m_m3) y = y * 181.0 / 256.0;
        r = $rtoi(y + ((y >= 0.0) ? 0.5 : -0.5));
        if (r > 8191)  r = 8191;
        if (r < -8192) r = -8192;
        return r;
    endfunction

    task automatic check(bit ok, string req, int act, int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // called at a falling edge: compare, advance model by one rising edge
    task automatic cycle();
        int d;
        check(out_valid === pv[1], {pt[1], " out_valid"}, int'(out_valid), int'(pv[1]));
        if (pv[1] && out_valid === 1'b1) begin
            d = int'(out_sample) - pe[1];
            check(d <= TOL && d >= -TOL, {pt[1], " sample"}, int'(out_sample), pe[1]);
        end
        pv[1] = pv[0]; pe[1] = pe[0]; pt[1] = pt[0];
        pv[0] = in_valid;
        pe[0] = in_valid ? model_out(int'(i_in), int'(q_in)) : 0;
        pt[0] = cur;
        if (in_valid) m_acc = m_acc + (m_lp ? (m_tune & 32'hF800_0000) : m_tune);
        if (cfg_we) begin
            case (cfg_addr)
                3'd0: m_sh[7:0]    = cfg_wdata;
                3'd1: m_sh[15:8]   = cfg_wdata;
                3'd2: m_sh[23:16]  = cfg_wdata;
                3'd3: m_tune       = {cfg_wdata, m_sh};
                3'd4: m_phoff[7:0] = cfg_wdata;
                3'd5: m_phoff[15:8] = cfg_wdata;
                3'd6: begin m_inv = cfg_wdata[0]; m_lp = cfg_wdata[1]; m_m3 = cfg_wdata[2]; end
                default: ;
            endcase
        end
        @(negedge clk);
    endtask

    task automatic wr(logic [2:0] a, logic [7:0] d);
        cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d; in_valid = 1'b0;
        cycle();
        cfg_we = 1'b0;
    endtask

    task automatic run(int n, int iv, int qv, int istep, bit gap);
        for (int k = 0; k < n; k++) begin
            in_valid = gap ? (k % 2 == 0) : 1'b1;
            i_in = 14'(iv + k * istep);
            q_in = 14'(qv);
            cycle();
        end
        in_valid = 1'b0;
    endtask

    initial begin
        #(CLK_P * 200000);
        n_fail++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        pv[0] = 0; pv[1] = 0; pe[0] = 0; pe[1] = 0; pt[0] = "R1"; pt[1] = "R1";
        repeat (4) @(negedge clk);
        check(out_valid === 1'b0, "R1 out_valid in reset", int'(out_valid), 0);
        rst = 1'b0;
        @(negedge clk);
        check(out_valid === 1'b0, "R1 out_valid after reset", int'(out_valid), 0);
        // R1: default carrier and zero phase offset, I-only ramp
        cur = "R1"; run(24, -6000, 0, 500, 1'b0);
        // R5: Q-only, then mixed I/Q
        cur = "R5"; run(30, 0, 5000, 0, 1'b0);
        run(30, 3000, -2000, 17, 1'b0);
        // R4: gapped valid
        cur = "R4"; run(40, 3000, -2000, 0, 1'b1);
        // R2: partial tuning write must not change the carrier
        cur = "R2"; wr(3'd0, 8'h00); wr(3'd1, 8'h00); wr(3'd2, 8'h10);
        run(20, 4000, 1000, 0, 1'b0);
        wr(3'd3, 8'h04);
        run(30, 4000, 1000, 0, 1'b0);
        // R3: phase offset
        cur = "R3"; wr(3'd4, 8'h40); run(10, 4000, 0, 0, 1'b0);
        wr(3'd5, 8'h40); run(20, 4000, 0, 0, 1'b0);
        // R6: sideband inversion
        cur = "R6"; wr(3'd6, 8'h01); run(30, 4000, 4000, 0, 1'b0);
        // R7: low-power mode with new coarse step
        cur = "R7"; wr(3'd3, 8'h1B); wr(3'd6, 8'h02);
        run(40, -5000, 3000, 200, 1'b0);
        run(20, 2000, 2000, 0, 1'b1);
        // R8: -3 dB scaling at full scale
        cur = "R8"; wr(3'd6, 8'h04); run(30, 8191, 8191, 0, 1'b0);
        run(20, -8192, 8191, 0, 1'b0);
        // R9: saturation without scaling
        cur = "R9"; wr(3'd6, 8'h00); run(30, 8191, 8191, 0, 1'b0);
        run(30, -8192, -8192, 0, 1'b0);
        run(3, 0, 0, 0, 1'b1);
        in_valid = 1'b0;
        cycle(); cycle(); cycle();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule